// File: doc/BRIEF.md
# Machine-Mode Interrupt Acceptance Unit

This block decides, for a single-hart core with one timer interrupt source and no interrupt controller, when the core leaves its normal flow for the trap handler. A free-running cycle prescaler raises a request once per period, and a pending latch holds that request until it is taken. The core reports each retiring instruction with its next PC. At that boundary the unit checks the pending latch against the global interrupt-enable bit. If the interrupt is taken, the unit saves the next PC and the cause, updates the enable bits, and pulses a redirect to the trap base.

The core also reports the retirement of a return-from-trap instruction. On that event the unit restores the enable state. Software can load both enable bits through a small write port. A scratch register with no side effect gives an atomic swap: the old value is visible while the new value is written.

Top module: `irq_accept`

## Requirements
- R1: An interrupt is taken only at an edge where `retire_i` is 1. While no instruction retires, a pending request causes no redirect, however long it waits.
- R2: When `mie_o` is 0, retiring instructions take no interrupt, and `pending_o` stays 1 until the request is taken.
- R3: Taking an interrupt loads `mpie_o` with the old `mie_o`, clears `mie_o` to 0 and clears `pending_o`. All of these are visible after the accepting edge.
- R4: A retiring return-from-trap (`retire_i` and `ret_i` both 1) loads `mie_o` from the old `mpie_o` and sets `mpie_o` to 1.
- R5: After an accepting edge, `cause_o` reads 0x80000007 (bit 31 = interrupt flag, low field = 7) and `epc_o` holds the `next_pc_i` that was presented with the retiring instruction.
- R6: `redirect_o` is high for exactly the one cycle after the accepting edge, and during that cycle `redirect_pc_o` equals `TRAP_BASE`.
- R7: The prescaler sets `pending_o` once every `TICK_CYCLES` clock cycles, counted from the release of reset. Consecutive rising edges of `pending_o` are `TICK_CYCLES` cycles apart.
- R8: A prescaler tick at the same edge as an acceptance leaves `pending_o` at 1, so that request is not lost.
- R9: At a return-from-trap boundary no interrupt is taken. The request is judged at the next boundary against the restored `mie_o`.
- R10: `scr_rdata_o` always shows the scratch register. At an edge with `scr_swap_i` set, the register takes `scr_wdata_i`, and the value read in that same cycle is the old one. A swap does not change the enable bits.
- R11: After reset, `mie_o`, `mpie_o`, `pending_o`, `redirect_o` and the scratch value are all 0.
- R12: `stat_we_i` loads `mie_o` and `mpie_o` from `stat_mie_i` and `stat_mpie_i` at an edge where no interrupt is taken and no return-from-trap retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| retire_i | input | 1 | An instruction retires this cycle |
| next_pc_i | input | XLEN | Next PC of the retiring instruction |
| ret_i | input | 1 | The retiring instruction is a return-from-trap |
| stat_we_i | input | 1 | Write the enable bits |
| stat_mie_i | input | 1 | New global enable value |
| stat_mpie_i | input | 1 | New previous-enable value |
| scr_swap_i | input | 1 | Swap the scratch register |
| scr_wdata_i | input | XLEN | Value written by a swap |
| scr_rdata_o | output | XLEN | Current scratch value |
| mie_o | output | 1 | Global interrupt enable |
| mpie_o | output | 1 | Previous interrupt enable |
| pending_o | output | 1 | Timer request pending |
| redirect_o | output | 1 | One-cycle redirect to the trap path |
| redirect_pc_o | output | XLEN | Redirect target |
| epc_o | output | XLEN | Saved PC of the interrupted flow |
| cause_o | output | XLEN | Trap cause |

## Verification
The bench holds a request pending while interrupts are masked and also while no instruction retires. A unit that sampled the request continuously, or ignored the enable bit, would redirect in the middle of an instruction or in a masked region. It places a return-from-trap in the same cycle as a pending request, with the old enable set and the restored enable clear. A unit that judged the request against the stale enable would trap at the return itself. It also times an acceptance to coincide with the next prescaler tick. A unit that let the clear win would drop that request, and the bench would see `pending_o` fall.

// File: rtl/irq_accept.sv
module irq_accept #(
  parameter int               XLEN        = 32,
  parameter int               TICK_CYCLES = 1_000_000,
  parameter logic [XLEN-1:0]  TRAP_BASE   = XLEN'(32'h0000_0100)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            retire_i,
  input  logic [XLEN-1:0] next_pc_i,
  input  logic            ret_i,
  input  logic            stat_we_i,
  input  logic            stat_mie_i,
  input  logic            stat_mpie_i,
  input  logic            scr_swap_i,
  input  logic [XLEN-1:0] scr_wdata_i,
  output logic [XLEN-1:0] scr_rdata_o,
  output logic            mie_o,
  output logic            mpie_o,
  output logic            pending_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] cause_o
);
  localparam int              CW         = $clog2(TICK_CYCLES + 1);
  localparam logic [XLEN-1:0] TIMER_CODE = (XLEN'(1) << (XLEN - 1)) | XLEN'(7);

  logic [CW-1:0]   tick_cnt;
  logic            tick;
  logic            take;
  logic            mret;
  logic [XLEN-1:0] scratch;

  assign tick = (tick_cnt == CW'(TICK_CYCLES - 1));
  assign mret = retire_i & ret_i;
  assign take = retire_i & ~ret_i & pending_o & mie_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_cnt <= '0;
    else if (tick) tick_cnt <= '0;
    else tick_cnt <= tick_cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending_o <= 1'b0;
    else if (tick) pending_o <= 1'b1;
    else if (take) pending_o <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mie_o  <= 1'b0;
      mpie_o <= 1'b0;
    end else if (take) begin
      mpie_o <= mie_o;
      mie_o  <= 1'b0;
    end else if (mret) begin
      mie_o  <= mpie_o;
      mpie_o <= 1'b1;
    end else if (stat_we_i) begin
      mie_o  <= stat_mie_i;
      mpie_o <= stat_mpie_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_o <= 1'b0;
      epc_o      <= '0;
      cause_o    <= '0;
    end else begin
      redirect_o <= take;
      if (take) begin
        epc_o   <= next_pc_i;
        cause_o <= TIMER_CODE;
      end
    end
  end

  assign redirect_pc_o = TRAP_BASE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scratch <= '0;
    else if (scr_swap_i) scratch <= scr_wdata_i;
  end

  assign scr_rdata_o = scratch;
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] TRAP_BASE = '0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            retire_i,
  input logic            ret_i,
  input logic            scr_swap_i,
  input logic [XLEN-1:0] scr_wdata_i,
  input logic [XLEN-1:0] scr_rdata_o,
  input logic            mie_o,
  input logic            mpie_o,
  input logic            pending_o,
  input logic            redirect_o,
  input logic [XLEN-1:0] redirect_pc_o,
  input logic [XLEN-1:0] cause_o
);
  localparam logic [XLEN-1:0] TIMER_CODE = (XLEN'(1) << (XLEN - 1)) | XLEN'(7);

  AST_NO_TAKE_OFF_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !(retire_i && !ret_i && mie_o) |=> !redirect_o); // R1

  AST_PENDING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o && !(retire_i && !ret_i && mie_o)) |=> pending_o); // R2

  AST_ENTRY_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && !ret_i && pending_o && mie_o) |=> (redirect_o && mpie_o && !mie_o)); // R3

  AST_RETURN_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && ret_i) |=> (mpie_o && (mie_o == $past(mpie_o)))); // R4

  AST_CAUSE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (cause_o == TIMER_CODE)); // R5

  AST_REDIRECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |=> !redirect_o); // R6

  AST_REDIRECT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (redirect_pc_o == TRAP_BASE)); // R6

  AST_RETURN_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && ret_i) |=> !redirect_o); // R9

  AST_SWAP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    scr_swap_i |=> (scr_rdata_o == $past(scr_wdata_i))); // R10
endmodule

bind irq_accept irq_accept_chk #(.XLEN(XLEN), .TRAP_BASE(TRAP_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .ret_i(ret_i),
  .scr_swap_i(scr_swap_i), .scr_wdata_i(scr_wdata_i), .scr_rdata_o(scr_rdata_o),
  .mie_o(mie_o), .mpie_o(mpie_o), .pending_o(pending_o), .redirect_o(redirect_o),
  .redirect_pc_o(redirect_pc_o), .cause_o(cause_o)
);

// File: tb/irq_accept_tb.sv
module irq_accept_tb;
  localparam int          XLEN = 32;
  localparam int          P    = 40;
  localparam logic [31:0] TB   = 32'h0000_0200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic retire_i = 1'b0, ret_i = 1'b0, stat_we_i = 1'b0, stat_mie_i = 1'b0, stat_mpie_i = 1'b0;
  logic scr_swap_i = 1'b0;
  logic [XLEN-1:0] next_pc_i = '0, scr_wdata_i = '0;
  logic [XLEN-1:0] scr_rdata_o, redirect_pc_o, epc_o, cause_o;
  logic mie_o, mpie_o, pending_o, redirect_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  irq_accept #(.XLEN(XLEN), .TICK_CYCLES(P), .TRAP_BASE(TB)) u_dut (
    .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .next_pc_i(next_pc_i), .ret_i(ret_i),
    .stat_we_i(stat_we_i), .stat_mie_i(stat_mie_i), .stat_mpie_i(stat_mpie_i),
    .scr_swap_i(scr_swap_i), .scr_wdata_i(scr_wdata_i), .scr_rdata_o(scr_rdata_o),
    .mie_o(mie_o), .mpie_o(mpie_o), .pending_o(pending_o), .redirect_o(redirect_o),
    .redirect_pc_o(redirect_pc_o), .epc_o(epc_o), .cause_o(cause_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic idle();
    retire_i = 0; ret_i = 0; stat_we_i = 0; scr_swap_i = 0;
  endtask

  task automatic wait_pend();
    while (!pending_o) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R11 mie", 32'(mie_o), 0);
    check("R11 mpie", 32'(mpie_o), 0);
    check("R11 pending", 32'(pending_o), 0);
    check("R11 redirect", 32'(redirect_o), 0);
    check("R11 scratch", scr_rdata_o, 0);
  endtask

  task automatic t_scratch();
    scr_swap_i = 1; scr_wdata_i = 32'hA5A5_0001;
    check("R10 old value in swap cycle", scr_rdata_o, 0);
    @(negedge clk);
    scr_wdata_i = 32'h0000_BEEF;
    check("R10 first swap stored", scr_rdata_o, 32'hA5A5_0001);
    @(negedge clk);
    idle();
    check("R10 second swap stored", scr_rdata_o, 32'h0000_BEEF);
    check("R10 mie untouched", 32'(mie_o), 0);
    check("R10 mpie untouched", 32'(mpie_o), 0);
  endtask

  task automatic t_masked();
    wait_pend();
    retire_i = 1; next_pc_i = 32'h100;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R2 masked no redirect", 32'(redirect_o), 0);
      check("R2 pending held", 32'(pending_o), 1);
    end
    idle();
    stat_we_i = 1; stat_mie_i = 1; stat_mpie_i = 0;
    @(negedge clk);
    idle();
    check("R12 status write mie", 32'(mie_o), 1);
    check("R12 status write mpie", 32'(mpie_o), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1 no retire no redirect", 32'(redirect_o), 0);
    end
  endtask

  task automatic t_accept();
    retire_i = 1; next_pc_i = 32'h0000_1234;
    @(negedge clk);
    idle();
    check("R6 redirect high", 32'(redirect_o), 1);
    check("R6 redirect target", redirect_pc_o, TB);
    check("R5 epc", epc_o, 32'h0000_1234);
    check("R5 cause", cause_o, 32'h8000_0007);
    check("R3 mie cleared", 32'(mie_o), 0);
    check("R3 mpie saved", 32'(mpie_o), 1);
    check("R3 pending cleared", 32'(pending_o), 0);
    @(negedge clk);
    check("R6 redirect one cycle", 32'(redirect_o), 0);
  endtask

  task automatic t_return();
    retire_i = 1; ret_i = 1;
    @(negedge clk);
    idle();
    check("R4 mie restored", 32'(mie_o), 1);
    check("R4 mpie set", 32'(mpie_o), 1);
    stat_we_i = 1; stat_mie_i = 0; stat_mpie_i = 0;
    @(negedge clk);
    idle();
    retire_i = 1; ret_i = 1;
    @(negedge clk);
    idle();
    check("R4 mie from cleared mpie", 32'(mie_o), 0);
    check("R4 mpie set again", 32'(mpie_o), 1);
  endtask

  task automatic t_ret_race();
    wait_pend();
    stat_we_i = 1; stat_mie_i = 1; stat_mpie_i = 0;
    @(negedge clk);
    idle();
    retire_i = 1; ret_i = 1;
    @(negedge clk);
    idle();
    check("R9 no take at return", 32'(redirect_o), 0);
    check("R9 mie restored to 0", 32'(mie_o), 0);
    check("R9 pending kept", 32'(pending_o), 1);
    retire_i = 1;
    @(negedge clk);
    idle();
    check("R9 judged on restored mie", 32'(redirect_o), 0);
    stat_we_i = 1; stat_mie_i = 0; stat_mpie_i = 1;
    @(negedge clk);
    idle();
    retire_i = 1; ret_i = 1;
    @(negedge clk);
    idle();
    check("R9 no take at enabling return", 32'(redirect_o), 0);
    check("R9 mie now 1", 32'(mie_o), 1);
    retire_i = 1; next_pc_i = 32'h0000_2000;
    @(negedge clk);
    idle();
    check("R9 taken at next boundary", 32'(redirect_o), 1);
  endtask

  task automatic t_period();
    int c0;
    wait_pend();
    c0 = cyc;
    stat_we_i = 1; stat_mie_i = 1; stat_mpie_i = 0;
    @(negedge clk);
    idle();
    retire_i = 1;
    @(negedge clk);
    idle();
    check("R7 cleared before next tick", 32'(pending_o), 0);
    wait_pend();
    check("R7 tick spacing", 32'(cyc - c0), P);
  endtask

  task automatic t_collide();
    stat_we_i = 1; stat_mie_i = 1; stat_mpie_i = 0;
    @(negedge clk);
    idle();
    repeat (P - 2) @(negedge clk);
    check("R1 still pending without retire", 32'(pending_o), 1);
    retire_i = 1; next_pc_i = 32'h0000_3000;
    @(negedge clk);
    idle();
    check("R8 taken on tick edge", 32'(redirect_o), 1);
    check("R8 pending survives", 32'(pending_o), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_scratch();
    t_masked();
    t_accept();
    t_return();
    t_ret_race();
    t_period();
    t_collide();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule